// File: doc/BRIEF.md
# Class-Sorting Dispatch Stage with Three Issue Queues

This block sits between instruction decode and the execution units of a superscalar core. Decoded instructions arrive from fetch, up to four per cycle, each with a two-bit class tag and a payload. They wait in an in-order decode queue of twelve entries. Each cycle, up to three of the oldest are moved into one of three issue queues: floating-point, vector, or general (every other class). Each issue queue holds four entries. Its head leaves for its functional unit whenever that unit signals ready. Different classes therefore leave out of program order with respect to one another.

Moves out of the decode queue are strictly in program order. If the oldest waiting instruction cannot move because its issue queue is full, nothing behind it moves either. The block stamps every accepted instruction with a running sequence tag, so that a later stage can put results back in order. A flush empties every queue at once.

Top module: `iq_dispatch`

## Requirements
- R1: `fetch_ready` is high exactly when the decode queue has at least four free slots. When it is high and `flush` is low, the first `fetch_cnt` lanes are accepted, lane 0 being the oldest. A `fetch_cnt` above 4 counts as 4. When `fetch_ready` is low, the fetch inputs are ignored.
- R2: The decode queue never holds more than 12 instructions.
- R3: The class tag selects the issue queue and the issue port. Tag 2'b01 goes to port 0 (floating-point), tag 2'b10 goes to port 1 (vector), and tags 2'b00 and 2'b11 go to port 2 (general).
- R4: At most three instructions leave the decode queue per cycle, oldest first. Only instructions that were already present at the start of the cycle can leave.
- R5: An instruction moves only if its issue queue has room. Room is counted from the start-of-cycle occupancy plus the moves already made that cycle; an issue in the same cycle does not free a slot. The first instruction that cannot move blocks every younger one in that cycle.
- R6: Each issue queue holds at most four entries and issues them in the order they arrived.
- R7: If `fu_ready[q]` is high and issue queue q is non-empty in cycle t, then `issue_valid[q]` is high in cycle t+1 and carries the head entry's payload and tag. Otherwise `issue_valid[q]` is low in cycle t+1.
- R8: Each issue queue drains only under its own ready input. A stalled unit holds back no other queue's issue.
- R9: Accepted instructions get sequence tags numbered consecutively in lane order, starting at 0 after reset and wrapping modulo 2^8. A flush does not restart the numbering.
- R10: A flush empties the decode queue and all three issue queues in one cycle. No issue strobe appears in the following cycle, and fetch lanes offered in the flush cycle are dropped.
- R11: After reset, all queues are empty, every `issue_valid` bit is low and `fetch_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties all queues |
| fetch_cnt | input | 3 | Number of valid fetch lanes, from lane 0 upward |
| fetch_cls | input | 8 | Two-bit class tag per lane, lane i at bits [2i+1:2i] |
| fetch_data | input | 64 | 16-bit payload per lane, lane i at bits [16i+15:16i] |
| fetch_ready | output | 1 | Decode queue can take a full fetch group |
| fu_ready | input | 3 | Unit ready: bit 0 floating-point, bit 1 vector, bit 2 general |
| issue_valid | output | 3 | Issue strobe per unit, registered |
| issue_data | output | 48 | Issued payload per unit, port q at bits [16q+15:16q] |
| issue_seq | output | 24 | Issued sequence tag per unit, port q at bits [8q+7:8q] |

## Verification
The bench first streams mixed classes with every unit ready, which shows whether routing and the payload and tag sent to each port are right. It then sends only floating-point work with its unit stalled while the general unit is ready. This separates true head-of-line blocking from a design that lets younger instructions skip past a full queue, and shows that a blocked class freezes the decode queue. Long runs with random ready patterns and random lane counts, including counts above four, exercise independent draining, clipping of over-large counts and tag wraparound. A flush that arrives together with a full fetch group shows whether all four queues clear and whether the fetch group is dropped.

// File: rtl/iqd_pkg.sv
`timescale 1ns/1ps
package iqd_pkg;
  localparam int NUM_Q  = 3;
  localparam int CLS_W  = 2;
  localparam int PORT_FP  = 0;
  localparam int PORT_VEC = 1;
  localparam int PORT_GEN = 2;

  typedef enum logic [1:0] {
    CLS_INT  = 2'b00,
    CLS_FP   = 2'b01,
    CLS_VEC  = 2'b10,
    CLS_MISC = 2'b11
  } icls_e;

  // Class tag to issue-port index (R3)
  function automatic logic [1:0] route_q(input logic [1:0] cls);
    case (icls_e'(cls))
      CLS_FP:  route_q = 2'(PORT_FP);
      CLS_VEC: route_q = 2'(PORT_VEC);
      default: route_q = 2'(PORT_GEN);
    endcase
  endfunction
endpackage

// File: rtl/iqd_mpfifo.sv
`timescale 1ns/1ps
module iqd_mpfifo #(
  parameter int DEPTH = 12,
  parameter int W     = 26,
  parameter int IN_N  = 4,
  parameter int OUT_N = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IN_W  = $clog2(IN_N + 1),
  localparam int OUT_W = $clog2(OUT_N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [IN_W-1:0]    push_n,
  input  logic [IN_N*W-1:0]  push_data,
  input  logic [OUT_W-1:0]   pop_n,
  output logic [OUT_N*W-1:0] peek_data,
  output logic [CNT_W-1:0]   count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] tail;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] base,
                                            input int unsigned off);
    int unsigned s;
    s = (32'(base) + off) % DEPTH;
    return PTR_W'(s);
  endfunction

  assign tail  = wrap(head_q, 32'(cnt_q));
  assign count = cnt_q;

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_N; i++) begin
      if (!flush && i < int'(push_n))
        mem[wrap(tail, i)] <= push_data[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= wrap(head_q, 32'(pop_n));
      cnt_q  <= cnt_q + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  always_comb begin
    for (int j = 0; j < OUT_N; j++)
      peek_data[j*W +: W] = mem[wrap(head_q, j)];
  end
endmodule

// File: rtl/iqd_dispatch_sel.sv
`timescale 1ns/1ps
module iqd_dispatch_sel import iqd_pkg::*; #(
  parameter int DISP_W   = 3,
  parameter int W        = 26,
  parameter int PAY_W    = 24,
  parameter int IQ_DEPTH = 4,
  parameter int DQ_CNT_W = 4,
  parameter int IQ_CNT_W = 3,
  localparam int PN_W    = $clog2(DISP_W + 1)
) (
  input  logic [DQ_CNT_W-1:0]             dq_count,
  input  logic [DISP_W*W-1:0]             dq_peek,
  input  logic [NUM_Q*IQ_CNT_W-1:0]       iq_count,
  output logic [DISP_W-1:0]               disp_mask,
  output logic [NUM_Q*PN_W-1:0]           iq_push_n,
  output logic [NUM_Q*DISP_W*PAY_W-1:0]   iq_push_data
);
  int         add_c [NUM_Q];
  logic       go;
  logic [1:0] dst;

  always_comb begin
    go           = 1'b1;
    disp_mask    = '0;
    iq_push_data = '0;
    dst          = '0;
    for (int q = 0; q < NUM_Q; q++) add_c[q] = 0;
    for (int k = 0; k < DISP_W; k++) begin
      dst = route_q(dq_peek[k*W + PAY_W +: CLS_W]);
      if (go && k < int'(dq_count) &&
          (int'(iq_count[int'(dst)*IQ_CNT_W +: IQ_CNT_W]) + add_c[dst]) < IQ_DEPTH) begin
        disp_mask[k] = 1'b1;
        iq_push_data[(int'(dst)*DISP_W + add_c[dst])*PAY_W +: PAY_W] = dq_peek[k*W +: PAY_W];
        add_c[dst] = add_c[dst] + 1;
      end else begin
        go = 1'b0;
      end
    end
    for (int q = 0; q < NUM_Q; q++)
      iq_push_n[q*PN_W +: PN_W] = PN_W'(add_c[q]);
  end
endmodule

// File: rtl/iqd_issue_reg.sv
`timescale 1ns/1ps
module iqd_issue_reg #(
  parameter int NQ = 3,
  parameter int W  = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [NQ-1:0] fu_ready,
  input  logic [NQ-1:0] nonempty,
  input  logic [NQ*W-1:0] head,
  output logic [NQ-1:0] pop,
  output logic [NQ-1:0] valid_q,
  output logic [NQ*W-1:0] entry_q
);
  assign pop = fu_ready & nonempty & {NQ{~flush}};

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= pop;
  end

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_port
      always_ff @(posedge clk) begin
        if (pop[q]) entry_q[q*W +: W] <= head[q*W +: W];
      end
    end
  endgenerate
endmodule

// File: rtl/iq_dispatch.sv
`timescale 1ns/1ps
module iq_dispatch import iqd_pkg::*; #(
  parameter int FETCH_W  = 4,
  parameter int DQ_DEPTH = 12,
  parameter int DISP_W   = 3,
  parameter int IQ_DEPTH = 4,
  parameter int PW       = 16,
  parameter int SEQ_W    = 8,
  localparam int FC_W    = $clog2(FETCH_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic [FC_W-1:0]        fetch_cnt,
  input  logic [FETCH_W*CLS_W-1:0] fetch_cls,
  input  logic [FETCH_W*PW-1:0]  fetch_data,
  output logic                   fetch_ready,
  input  logic [NUM_Q-1:0]       fu_ready,
  output logic [NUM_Q-1:0]       issue_valid,
  output logic [NUM_Q*PW-1:0]    issue_data,
  output logic [NUM_Q*SEQ_W-1:0] issue_seq
);
  localparam int PAY_W    = SEQ_W + PW;
  localparam int EW       = CLS_W + PAY_W;
  localparam int DQ_CNT_W = $clog2(DQ_DEPTH + 1);
  localparam int IQ_CNT_W = $clog2(IQ_DEPTH + 1);
  localparam int DN_W     = $clog2(DISP_W + 1);

  logic [SEQ_W-1:0]            seq_q;
  logic [FC_W-1:0]             acc_n;
  logic [FETCH_W*EW-1:0]       dq_push_data;
  logic [DQ_CNT_W-1:0]         dq_count;
  logic [DISP_W*EW-1:0]        dq_peek;
  logic [DISP_W-1:0]           disp_mask;
  logic [DN_W-1:0]             disp_n;
  logic [NUM_Q*DN_W-1:0]       iq_push_n;
  logic [NUM_Q*DISP_W*PAY_W-1:0] iq_push_data;
  logic [NUM_Q*IQ_CNT_W-1:0]   iq_count;
  logic [NUM_Q*PAY_W-1:0]      iq_head;
  logic [NUM_Q-1:0]            iq_nonempty;
  logic [NUM_Q-1:0]            iq_pop;
  logic [NUM_Q*PAY_W-1:0]      issue_entry;

  // accept side
  assign fetch_ready = (32'(dq_count) + FETCH_W) <= DQ_DEPTH;
  assign acc_n = (!fetch_ready || flush) ? '0 :
                 ((32'(fetch_cnt) > FETCH_W) ? FC_W'(FETCH_W) : fetch_cnt);

  generate
    for (genvar i = 0; i < FETCH_W; i++) begin : g_lane
      assign dq_push_data[i*EW +: EW] = {fetch_cls[i*CLS_W +: CLS_W],
                                         seq_q + SEQ_W'(i),
                                         fetch_data[i*PW +: PW]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) seq_q <= '0;
    else     seq_q <= seq_q + SEQ_W'(acc_n);
  end

  iqd_mpfifo #(
    .DEPTH(DQ_DEPTH), .W(EW), .IN_N(FETCH_W), .OUT_N(DISP_W)
  ) u_decode_q (
    .clk(clk), .rst(rst), .flush(flush),
    .push_n(acc_n), .push_data(dq_push_data),
    .pop_n(disp_n), .peek_data(dq_peek), .count(dq_count)
  );

  iqd_dispatch_sel #(
    .DISP_W(DISP_W), .W(EW), .PAY_W(PAY_W), .IQ_DEPTH(IQ_DEPTH),
    .DQ_CNT_W(DQ_CNT_W), .IQ_CNT_W(IQ_CNT_W)
  ) u_sel (
    .dq_count(dq_count), .dq_peek(dq_peek), .iq_count(iq_count),
    .disp_mask(disp_mask), .iq_push_n(iq_push_n), .iq_push_data(iq_push_data)
  );

  assign disp_n = flush ? '0 : DN_W'($countones(disp_mask));

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_iq
      logic [DN_W-1:0] push_n_g;
      assign push_n_g = flush ? '0 : iq_push_n[q*DN_W +: DN_W];
      iqd_mpfifo #(
        .DEPTH(IQ_DEPTH), .W(PAY_W), .IN_N(DISP_W), .OUT_N(1)
      ) u_issue_q (
        .clk(clk), .rst(rst), .flush(flush),
        .push_n(push_n_g),
        .push_data(iq_push_data[q*DISP_W*PAY_W +: DISP_W*PAY_W]),
        .pop_n(iq_pop[q]),
        .peek_data(iq_head[q*PAY_W +: PAY_W]),
        .count(iq_count[q*IQ_CNT_W +: IQ_CNT_W])
      );
      assign iq_nonempty[q] = iq_count[q*IQ_CNT_W +: IQ_CNT_W] != '0;
      assign issue_data[q*PW +: PW]     = issue_entry[q*PAY_W +: PW];
      assign issue_seq[q*SEQ_W +: SEQ_W] = issue_entry[q*PAY_W + PW +: SEQ_W];
    end
  endgenerate

  iqd_issue_reg #(.NQ(NUM_Q), .W(PAY_W)) u_issue (
    .clk(clk), .rst(rst), .flush(flush),
    .fu_ready(fu_ready), .nonempty(iq_nonempty), .head(iq_head),
    .pop(iq_pop), .valid_q(issue_valid), .entry_q(issue_entry)
  );
endmodule

// File: rtl/iq_dispatch_chk.sv
`timescale 1ns/1ps
module iq_dispatch_chk import iqd_pkg::*; #(
  parameter int DQ_DEPTH = 12,
  parameter int IQ_DEPTH = 4,
  parameter int DISP_W   = 3,
  parameter int DQ_CNT_W = 4,
  parameter int IQ_CNT_W = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      flush,
  input logic [NUM_Q-1:0]          fu_ready,
  input logic [NUM_Q-1:0]          issue_valid,
  input logic [DQ_CNT_W-1:0]       dq_count,
  input logic [NUM_Q*IQ_CNT_W-1:0] iq_count,
  input logic [DISP_W-1:0]         disp_mask,
  input logic [1:0]                dq_head_cls
);
  logic [1:0] head_dst;
  assign head_dst = route_q(dq_head_cls);

  assert_dq_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(dq_count) <= DQ_DEPTH);

  assert_hol_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (dq_count != '0 && !disp_mask[0]) |->
      int'(iq_count[int'(head_dst)*IQ_CNT_W +: IQ_CNT_W]) == IQ_DEPTH);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (dq_count == '0 && iq_count == '0 && issue_valid == '0));

  generate
    for (genvar k = 1; k < DISP_W; k++) begin : g_ord
      assert_disp_order_R4: assert property (@(posedge clk) disable iff (rst)
        disp_mask[k] |-> (disp_mask[k-1] && int'(dq_count) > k));
    end
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      assert_iq_bound_R6: assert property (@(posedge clk) disable iff (rst)
        int'(iq_count[q*IQ_CNT_W +: IQ_CNT_W]) <= IQ_DEPTH);
      assert_issue_cause_R7: assert property (@(posedge clk) disable iff (rst)
        issue_valid[q] |-> $past(fu_ready[q]));
    end
  endgenerate
endmodule

bind iq_dispatch iq_dispatch_chk #(
  .DQ_DEPTH(DQ_DEPTH), .IQ_DEPTH(IQ_DEPTH), .DISP_W(DISP_W),
  .DQ_CNT_W(DQ_CNT_W), .IQ_CNT_W(IQ_CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .fu_ready(fu_ready),
  .issue_valid(issue_valid), .dq_count(dq_count), .iq_count(iq_count),
  .disp_mask(disp_mask), .dq_head_cls(dq_peek[EW-CLS_W +: CLS_W])
);

// File: tb/iq_dispatch_tb.sv
`timescale 1ns/1ps
module iq_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 4, PW = 16, SW = 8, DQD = 12, IQD = 4, DW = 3, NQ = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [2:0]  fetch_cnt = '0;
  logic [7:0]  fetch_cls = '0;
  logic [63:0] fetch_data = '0;
  logic [2:0]  fu_ready = '0;
  logic        fetch_ready;
  logic [2:0]  issue_valid;
  logic [47:0] issue_data;
  logic [23:0] issue_seq;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_dispatch u_dut (
    .clk(clk), .rst(rst), .flush(flush), .fetch_cnt(fetch_cnt),
    .fetch_cls(fetch_cls), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .fu_ready(fu_ready), .issue_valid(issue_valid),
    .issue_data(issue_data), .issue_seq(issue_seq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R11 reset";

  // behavioural reference: entry = cls<<24 | seq<<16 | data
  int m_dq [DQD];
  int m_dqn = 0;
  int m_iq [NQ][IQD];
  int m_iqn [NQ];
  int m_seq = 0;
  bit exp_v [NQ];
  int exp_e [NQ];

  function automatic int route(int cls);
    if (cls == 1) return 0;
    if (cls == 2) return 1;
    return 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int start [NQ];
    int n, e, q, k;
    bit fr;
    if (rst || flush) begin
      m_dqn = 0;
      for (int i = 0; i < NQ; i++) begin m_iqn[i] = 0; exp_v[i] = 0; end
      if (rst) m_seq = 0;
    end else begin
      for (int i = 0; i < NQ; i++) start[i] = m_iqn[i];
      fr = (m_dqn + FW <= DQD);
      n = 0;
      while (n < DW && m_dqn > 0) begin
        e = m_dq[0];
        q = route((e >> 24) & 3);
        if (m_iqn[q] >= IQD) break;
        m_iq[q][m_iqn[q]] = e;
        m_iqn[q]++;
        for (int j = 0; j < DQD - 1; j++) m_dq[j] = m_dq[j+1];
        m_dqn--;
        n++;
      end
      for (int i = 0; i < NQ; i++) begin
        if (fu_ready[i] && start[i] > 0) begin
          exp_v[i] = 1;
          exp_e[i] = m_iq[i][0];
          for (int j = 0; j < IQD - 1; j++) m_iq[i][j] = m_iq[i][j+1];
          m_iqn[i]--;
        end else exp_v[i] = 0;
      end
      if (fr) begin
        k = (fetch_cnt > 4) ? 4 : int'(fetch_cnt);
        for (int i = 0; i < k; i++) begin
          m_dq[m_dqn] = (int'(fetch_cls[i*2 +: 2]) << 24) | ((m_seq & 255) << 16)
                        | int'(fetch_data[i*16 +: 16]);
          m_dqn++;
          m_seq++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(fetch_ready == (m_dqn + FW <= DQD), "R1 R2 fetch_ready", fetch_ready, m_dqn);
      for (int i = 0; i < NQ; i++) begin
        chk(issue_valid[i] == exp_v[i], "R7 R8 issue_valid", issue_valid[i], exp_v[i]);
        if (issue_valid[i] && exp_v[i]) begin
          chk(int'(issue_data[i*16 +: 16]) == (exp_e[i] & 16'hFFFF), "R3 R6 payload",
              issue_data[i*16 +: 16], exp_e[i] & 16'hFFFF);
          chk(int'(issue_seq[i*8 +: 8]) == ((exp_e[i] >> 16) & 255), "R9 seq tag",
              issue_seq[i*8 +: 8], (exp_e[i] >> 16) & 255);
        end
      end
    end
  end

  task automatic cyc(input int cnt, input logic [7:0] cls, input logic [2:0] fu, input bit fl);
    @(negedge clk); #1;
    fetch_cnt  = 3'(cnt);
    fetch_cls  = cls;
    fetch_data = {$urandom, $urandom};
    fu_ready   = fu;
    flush      = fl;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(issue_valid == 3'b000, "R11 reset issue_valid", issue_valid, 0);
    chk(fetch_ready == 1'b1, "R11 reset fetch_ready", fetch_ready, 1);
    #1 rst = 1'b0;

    phase = "R3 routing all ready";
    for (int i = 0; i < 30; i++) cyc(4, 8'($urandom), 3'b111, 0);

    phase = "R5 head-of-line stall";
    cyc(0, 8'h00, 3'b000, 1);
    for (int i = 0; i < 6; i++) cyc(4, 8'h55, 3'b000, 0);
    cyc(4, 8'h00, 3'b100, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(fetch_ready == 1'b0, "R5 blocked decode queue", fetch_ready, 0);
      chk(issue_valid == 3'b000, "R5 R8 no issue while blocked", issue_valid, 0);
    end
    for (int i = 0; i < 20; i++) cyc(4, 8'h00, 3'b001, 0);

    phase = "R4 R6 burst release";
    for (int i = 0; i < 5; i++) cyc(4, 8'($urandom), 3'b000, 0);
    for (int i = 0; i < 20; i++) cyc(4, 8'($urandom), 3'b111, 0);

    phase = "R10 flush";
    for (int i = 0; i < 4; i++) cyc(4, 8'($urandom), 3'b000, 0);
    cyc(4, 8'($urandom), 3'b111, 1);
    cyc(0, 8'h00, 3'b111, 0);
    chk(issue_valid == 3'b000, "R10 no issue after flush", issue_valid, 0);
    chk(fetch_ready == 1'b1, "R10 decode queue empty after flush", fetch_ready, 1);
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b111, 0);
    chk(issue_valid == 3'b000, "R10 issue queues empty after flush", issue_valid, 0);

    phase = "R8 independent drain";
    for (int i = 0; i < 400; i++) cyc(4, 8'($urandom), 3'($urandom), 0);

    phase = "R1 lane count clip";
    for (int i = 0; i < 400; i++) cyc($urandom % 8, 8'($urandom), 3'($urandom), 0);

    phase = "R9 R10 random with flush";
    for (int i = 0; i < 1500; i++)
      cyc($urandom % 8, 8'($urandom), 3'($urandom), ($urandom % 40) == 0);

    cyc(0, 8'h00, 3'b111, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule